// File: doc/BRIEF.md
# Min-Max Space Vector Duty Modulator

This block turns a voltage reference in the stationary two-axis frame (alpha, beta) and a measured DC bus voltage into three half-bridge duty cycles. It rebuilds the three phase references from the two axis components and finds their largest and smallest values. It then shifts all three by the common-mode term that centres that spread, normalises each result by the bus voltage around mid-bus, and clamps it to the range 0 to 1. Carrier generation, dead time and sector dwell-time arithmetic are left to neighbouring blocks.

One sample is accepted through a valid/ready pair. The block computes the three numerators exactly: it works in doubled units, so no half-LSB is lost in the halving steps. A restoring divider per leg then produces each duty, and all three duties appear together on a registered output with a one-cycle valid pulse. Inputs are signed Q3.12 (4096 = 1.0). Duties are unsigned, with 15 fractional bits, so 32768 = 1.0 and 16384 = 0.5. A bus voltage of zero or below cannot be used for division: the block then presents mid-bus duties and raises an error flag with that result.

Top module: `svm_modulator`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, and all three duties and bus_err are 0.
- R2: A sample is taken on a clock edge where in_valid and in_ready are both 1. in_ready stays 0 from that edge until the result is presented. Exactly one out_valid pulse of one cycle follows, and it becomes visible 17 clock edges after the accepting edge.
- R3: The phase references, in doubled Q3.12 units, are w_a = 2*alpha, w_b = p - alpha and w_c = -alpha - p, where p = floor((28378*beta + 8192) / 16384). The constant 28378 is the value of sqrt(3)/2 with 15 fractional bits, and the product is rounded to nearest with halves rounded up.
- R4: For a positive bus voltage v, let N = 2*w_x - max(w) - min(w) + 2*v and D = 4*v. Each duty is then floor(32768*N/D), which equals (v_x + cm + v/2)/v with cm = -(max+min)/2.
- R5: A leg whose N is 0 or below outputs duty 0, and a leg whose N is D or above outputs 32768 (1.0).
- R6: With alpha = 0, beta = 0 and any positive bus voltage, all three duties are exactly 16384, whether the bus voltage code is odd or even.
- R7: With a bus voltage of 0 or below, all three duties are 16384 and bus_err is 1 with that result. For a positive bus voltage, bus_err is 0.
- R8: Between out_valid pulses, duties and bus_err hold their last values. An in_valid raised while in_ready is 0 is ignored: it produces no result and does not change the pending one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block idle and able to take a sample |
| ref_alpha | input | 16 | Alpha-axis reference, signed Q3.12 |
| ref_beta | input | 16 | Beta-axis reference, signed Q3.12 |
| bus_v | input | 16 | DC bus voltage, signed Q3.12 |
| out_valid | output | 1 | One-cycle pulse: duties updated |
| duty_a | output | 16 | Leg A duty, 32768 = 1.0 |
| duty_b | output | 16 | Leg B duty, 32768 = 1.0 |
| duty_c | output | 16 | Leg C duty, 32768 = 1.0 |
| bus_err | output | 1 | Last result used a non-positive bus voltage |

## Verification
The hardest case to reach from the ports is a sample offered while the divider is mid-run. in_ready drops for only 17 cycles, so the driver keeps in_valid high with unrelated data through the first five busy cycles. The scoreboard then shows that only the original result arrives, and no extra one. The clamps at both ends are reached with large single-axis references against a small bus, where one leg saturates high and the other two low in the same sample. A pseudo-random sweep covers the extreme codes of all three inputs and the non-positive bus values.

// File: rtl/svm_pkg.sv
package svm_pkg;
    localparam int NUM_LEGS = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PREP = 2'd1,
        ST_RUN  = 2'd2,
        ST_FIN  = 2'd3
    } svm_state_e;
endpackage

// File: rtl/svm_phase_ref.sv
// Rebuilds the three phase references in doubled units (R3).
module svm_phase_ref #(
    parameter int IN_W   = 16,
    parameter int K_W    = 16,
    parameter int K_VAL  = 28378,
    parameter int K_FRAC = 15,
    parameter int W_W    = 19
) (
    input  logic signed [IN_W-1:0] alpha,
    input  logic signed [IN_W-1:0] beta,
    output logic signed [W_W-1:0]  w_a,
    output logic signed [W_W-1:0]  w_b,
    output logic signed [W_W-1:0]  w_c
);
    localparam int PROD_W = IN_W + K_W + 1;
    localparam logic signed [K_W:0]      K_S = (K_W+1)'(K_VAL);
    localparam logic signed [PROD_W-1:0] RND = PROD_W'(2 ** (K_FRAC - 2));

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;
    logic signed [W_W-1:0]    p_term;
    logic signed [W_W-1:0]    a_ext;

    always_comb begin
        prod   = PROD_W'(K_S) * PROD_W'(beta);
        scaled = (prod + RND) >>> (K_FRAC - 1);
        p_term = scaled[W_W-1:0];
        a_ext  = W_W'(alpha);
        w_a    = a_ext <<< 1;
        w_b    = p_term - a_ext;
        w_c    = -a_ext - p_term;
    end
endmodule

// File: rtl/svm_minmax_offset.sv
// Min-max common-mode injection, expressed as exact numerator/denominator (R4).
module svm_minmax_offset #(
    parameter int IN_W = 16,
    parameter int W_W  = 19,
    parameter int N_W  = 22
) (
    input  logic signed [W_W-1:0]  w_a,
    input  logic signed [W_W-1:0]  w_b,
    input  logic signed [W_W-1:0]  w_c,
    input  logic signed [IN_W-1:0] vdc,
    output logic signed [N_W-1:0]  num_a,
    output logic signed [N_W-1:0]  num_b,
    output logic signed [N_W-1:0]  num_c,
    output logic signed [N_W-1:0]  den,
    output logic                   vdc_bad
);
    logic signed [N_W-1:0] ea, eb, ec, mx, mn, bias, v_ext;

    always_comb begin
        ea    = N_W'(w_a);
        eb    = N_W'(w_b);
        ec    = N_W'(w_c);
        v_ext = N_W'(vdc);

        mx = (ea > eb) ? ea : eb;
        if (ec > mx) mx = ec;
        mn = (ea < eb) ? ea : eb;
        if (ec < mn) mn = ec;

        bias  = (v_ext <<< 1) - mx - mn;
        num_a = (ea <<< 1) + bias;
        num_b = (eb <<< 1) + bias;
        num_c = (ec <<< 1) + bias;
        den   = v_ext <<< 2;

        vdc_bad = vdc[IN_W-1] || (vdc == '0);
    end
endmodule

// File: rtl/svm_leg_divider.sv
// Restoring fraction divider for one leg with clamp flags (R4, R5).
module svm_leg_divider #(
    parameter int N_W = 22,
    parameter int Q_W = 15
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  step,
    input  logic signed [N_W-1:0] num,
    input  logic signed [N_W-1:0] den,
    output logic [Q_W:0]          duty
);
    typedef struct packed {
        logic [N_W-1:0] rem;
        logic [Q_W-1:0] quo;
        logic           lo;
        logic           hi;
    } div_t;

    div_t           div_d, div_q;
    logic [N_W-1:0] dbl;
    logic [N_W-1:0] den_u;
    logic           num_le0;

    always_comb begin
        div_d   = div_q;
        den_u   = den;
        dbl     = {div_q.rem[N_W-2:0], 1'b0};
        num_le0 = num[N_W-1] || (num == '0);
        if (load) begin
            div_d.lo  = num_le0;
            div_d.hi  = !num_le0 && (num >= den);
            div_d.rem = num;
            div_d.quo = '0;
        end else if (step) begin
            if (dbl >= den_u) begin
                div_d.rem = dbl - den_u;
                div_d.quo = {div_q.quo[Q_W-2:0], 1'b1};
            end else begin
                div_d.rem = dbl;
                div_d.quo = {div_q.quo[Q_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    always_comb begin
        if (div_q.lo)      duty = '0;
        else if (div_q.hi) duty = {1'b1, {Q_W{1'b0}}};
        else               duty = {1'b0, div_q.quo};
    end
endmodule

// File: rtl/svm_modulator.sv
module svm_modulator #(
    parameter int IN_W      = 16,
    parameter int DUTY_FRAC = 15,
    parameter int K_W       = 16,
    parameter int K_VAL     = 28378,
    parameter int K_FRAC    = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [IN_W-1:0]      ref_alpha,
    input  logic [IN_W-1:0]      ref_beta,
    input  logic [IN_W-1:0]      bus_v,
    output logic                 out_valid,
    output logic [DUTY_FRAC:0]   duty_a,
    output logic [DUTY_FRAC:0]   duty_b,
    output logic [DUTY_FRAC:0]   duty_c,
    output logic                 bus_err
);
    import svm_pkg::*;

    localparam int W_W    = IN_W + 3;
    localparam int N_W    = W_W + 3;
    localparam int DUTY_W = DUTY_FRAC + 1;
    localparam int CNT_W  = $clog2(DUTY_FRAC + 1);
    localparam logic [CNT_W-1:0]  LAST_STEP = CNT_W'(DUTY_FRAC - 1);
    localparam logic [DUTY_W-1:0] HALF      = DUTY_W'(2 ** (DUTY_FRAC - 1));

    typedef struct packed {
        svm_state_e         st;
        logic [CNT_W-1:0]   cnt;
        logic [IN_W-1:0]    alpha;
        logic [IN_W-1:0]    beta;
        logic [IN_W-1:0]    vdc;
        logic               bad;
        logic               vld;
        logic [DUTY_W-1:0]  da;
        logic [DUTY_W-1:0]  db;
        logic [DUTY_W-1:0]  dc;
        logic               err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic signed [W_W-1:0] w_a, w_b, w_c;
    logic signed [N_W-1:0] num_a, num_b, num_c, den;
    logic                  vdc_bad;
    logic signed [N_W-1:0] num_arr  [NUM_LEGS];
    logic [DUTY_W-1:0]     leg_duty [NUM_LEGS];
    logic                  div_load, div_step;

    svm_phase_ref #(
        .IN_W(IN_W), .K_W(K_W), .K_VAL(K_VAL), .K_FRAC(K_FRAC), .W_W(W_W)
    ) u_ref (
        .alpha(ctl_q.alpha), .beta(ctl_q.beta),
        .w_a(w_a), .w_b(w_b), .w_c(w_c)
    );

    svm_minmax_offset #(
        .IN_W(IN_W), .W_W(W_W), .N_W(N_W)
    ) u_off (
        .w_a(w_a), .w_b(w_b), .w_c(w_c), .vdc(ctl_q.vdc),
        .num_a(num_a), .num_b(num_b), .num_c(num_c), .den(den),
        .vdc_bad(vdc_bad)
    );

    assign num_arr[0] = num_a;
    assign num_arr[1] = num_b;
    assign num_arr[2] = num_c;
    assign div_load   = (ctl_q.st == ST_PREP);
    assign div_step   = (ctl_q.st == ST_RUN);

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        svm_leg_divider #(.N_W(N_W), .Q_W(DUTY_FRAC)) u_div (
            .clk(clk), .rst_n(rst_n),
            .load(div_load), .step(div_step),
            .num(num_arr[g]), .den(den),
            .duty(leg_duty[g])
        );
    end

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.vld = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    ctl_d.alpha = ref_alpha;
                    ctl_d.beta  = ref_beta;
                    ctl_d.vdc   = bus_v;
                    ctl_d.st    = ST_PREP;
                end
            end
            ST_PREP: begin
                ctl_d.bad = vdc_bad;
                ctl_d.cnt = '0;
                ctl_d.st  = ST_RUN;
            end
            ST_RUN: begin
                if (ctl_q.cnt == LAST_STEP) ctl_d.st = ST_FIN;
                else                        ctl_d.cnt = ctl_q.cnt + 1'b1;
            end
            ST_FIN: begin
                ctl_d.vld = 1'b1;
                ctl_d.err = ctl_q.bad;
                ctl_d.da  = ctl_q.bad ? HALF : leg_duty[0];
                ctl_d.db  = ctl_q.bad ? HALF : leg_duty[1];
                ctl_d.dc  = ctl_q.bad ? HALF : leg_duty[2];
                ctl_d.st  = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign in_ready  = (ctl_q.st == ST_IDLE);
    assign out_valid = ctl_q.vld;
    assign duty_a    = ctl_q.da;
    assign duty_b    = ctl_q.db;
    assign duty_c    = ctl_q.dc;
    assign bus_err   = ctl_q.err;
endmodule

// File: rtl/svm_modulator_chk.sv
module svm_modulator_chk #(
    parameter int DUTY_FRAC = 15
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic               out_valid,
    input logic [DUTY_FRAC:0] duty_a,
    input logic [DUTY_FRAC:0] duty_b,
    input logic [DUTY_FRAC:0] duty_c,
    input logic               bus_err
);
    localparam int LAT  = DUTY_FRAC + 2;
    localparam int LW   = $clog2(LAT + 2) + 1;
    localparam logic [DUTY_FRAC:0] ONE  = {1'b1, {DUTY_FRAC{1'b0}}};
    localparam logic [DUTY_FRAC:0] HALF = {2'b01, {(DUTY_FRAC-1){1'b0}}};

    logic [LW-1:0] since_acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      since_acc <= '0;
        else if (in_valid && in_ready)   since_acc <= LW'(1);
        else if (out_valid)              since_acc <= '0;
        else if (since_acc != '0)        since_acc <= since_acc + 1'b1;
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R2
    AST_READY_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_ready); // R2
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready); // R2
    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (since_acc == LW'(LAT + 1))); // R2
    AST_DUTY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_a <= ONE) && (duty_b <= ONE) && (duty_c <= ONE)); // R5
    AST_ERR_MIDBUS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && bus_err) |-> (duty_a == HALF && duty_b == HALF && duty_c == HALF)); // R7
    AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |=> ($stable(duty_a) && $stable(duty_b) && $stable(duty_c)) || out_valid); // R8
endmodule

bind svm_modulator svm_modulator_chk #(.DUTY_FRAC(DUTY_FRAC)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .duty_a(duty_a), .duty_b(duty_b), .duty_c(duty_c),
    .bus_err(bus_err)
);

// File: tb/tb_svm_modulator.sv
module tb_svm_modulator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] ref_alpha = '0;
    logic [15:0] ref_beta = '0;
    logic [15:0] bus_v = '0;
    logic        out_valid;
    logic [15:0] duty_a, duty_b, duty_c;
    logic        bus_err;

    svm_modulator dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .ref_alpha(ref_alpha), .ref_beta(ref_beta), .bus_v(bus_v),
        .out_valid(out_valid), .duty_a(duty_a), .duty_b(duty_b), .duty_c(duty_c),
        .bus_err(bus_err)
    );

    always #4 clk = ~clk;

    typedef struct {
        int     da, db, dc;
        int     err;
        longint acc;
        string  tag;
    } exp_t;

    exp_t   exp_q[$];
    exp_t   last_e;
    exp_t   mon_e;
    int     n_checks = 0;
    int     n_errors = 0;
    longint cyc = 0;
    bit     done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, string what, longint act, longint expv);
        n_checks++;
        if (act != expv) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Model of R3..R7
    function automatic exp_t model(int a, int b, int v, string tag);
        exp_t   e;
        longint p, mx, mn, dd, n;
        longint w[3];
        int     r[3];
        e.tag = tag;
        if (v <= 0) begin
            e.da = 16384; e.db = 16384; e.dc = 16384; e.err = 1;
            return e;
        end
        p    = (longint'(28378) * b + 8192) >>> 14;
        w[0] = 2 * longint'(a);
        w[1] = p - a;
        w[2] = -longint'(a) - p;
        mx = w[0]; mn = w[0];
        for (int k = 1; k < 3; k++) begin
            if (w[k] > mx) mx = w[k];
            if (w[k] < mn) mn = w[k];
        end
        dd = 4 * longint'(v);
        for (int k = 0; k < 3; k++) begin
            n = 2 * w[k] - mx - mn + 2 * longint'(v);
            if (n <= 0)       r[k] = 0;
            else if (n >= dd) r[k] = 32768;
            else              r[k] = int'((n * 32768) / dd);
        end
        e.da = r[0]; e.db = r[1]; e.dc = r[2]; e.err = 0;
        return e;
    endfunction

    task automatic drive_one(int a, int b, int v, string tag, int poke);
        exp_t e;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        ref_alpha = 16'(a); ref_beta = 16'(b); bus_v = 16'(v);
        in_valid  = 1'b1;
        e     = model(a, b, v, tag);
        e.acc = cyc;
        exp_q.push_back(e);
        for (int k = 0; k < poke; k++) begin
            @(negedge clk);
            // R8: offered while busy, must be ignored
            ref_alpha = 16'(12000 - 777 * k); ref_beta = 16'(-9000); bus_v = 16'(k - 2);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                chk("R2", "unexpected result count", 1, 0);
            end else begin
                mon_e = exp_q.pop_front();
                chk(mon_e.tag, "duty_a", duty_a, mon_e.da);
                chk(mon_e.tag, "duty_b", duty_b, mon_e.db);
                chk(mon_e.tag, "duty_c", duty_c, mon_e.dc);
                chk("R7", "bus_err", bus_err, mon_e.err);
                chk("R2", "latency", cyc - mon_e.acc, 18);
                last_e = mon_e;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int s;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "in_ready", in_ready, 1);
        chk("R1", "out_valid", out_valid, 0);
        chk("R1", "duty_a", duty_a, 0);
        chk("R1", "duty_b", duty_b, 0);
        chk("R1", "duty_c", duty_c, 0);
        chk("R1", "bus_err", bus_err, 0);

        drive_one(0, 0, 4096, "R6", 0);
        drive_one(0, 0, 4097, "R6", 0);
        drive_one(0, 0, 32767, "R6", 0);
        drive_one(1000, 500, 4096, "R4", 0);
        drive_one(0, 2000, 4096, "R3", 0);
        drive_one(-1500, -700, 6000, "R3", 0);
        drive_one(8000, 0, 4096, "R5", 0);
        drive_one(-32768, 32767, 32767, "R5", 0);
        drive_one(0, -20000, 1000, "R5", 0);
        drive_one(1200, 300, 0, "R7", 0);
        drive_one(1200, 300, -100, "R7", 0);
        drive_one(500, -400, 5000, "R8", 5);

        // R8: outputs held while idle
        while (exp_q.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
        chk("R8", "held duty_a", duty_a, last_e.da);
        chk("R8", "held duty_b", duty_b, last_e.db);
        chk("R8", "held duty_c", duty_c, last_e.dc);

        s = 32'h1234_5678;
        for (int i = 0; i < 24; i++) begin
            logic signed [15:0] ra, rb;
            int vv;
            s  = s * 1103515245 + 12345;
            ra = s[23:8];
            s  = s * 1103515245 + 12345;
            rb = s[27:12];
            s  = s * 1103515245 + 12345;
            vv = (s[7:0] == 8'd3) ? -int'(s[15:8]) : 64 + 8 * int'(s[19:8]);
            if (vv > 32767) vv = 32767;
            drive_one(int'(ra), int'(rb), vv, "R4", 0);
        end

        while (exp_q.size() != 0) @(negedge clk);
        repeat (20) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule